// File: doc/BRIEF.md
# Serial CRC Generator and Checker (degree 4)

This block divides a serial bit stream by the generator polynomial x^4 + x + 1 over GF(2), one bit per clock, most significant coefficient first. Addition is a carry-free XOR, so each step either shifts the working remainder left or shifts it and XORs in the generator, depending on the bit leaving the top. In encode mode the block repeats each accepted message bit on its serial output. After the message it appends the four remainder bits. These take the place of the four zero bits that multiplying the message by x^4 would add. In check mode it divides a received codeword and reports whether the remainder is zero.

The remainder register is updated in the direct form: the incoming bit is XORed into the feedback term. This gives the same remainder as shifting the message in and then pushing four zeros through a plain divider, but without spending the four extra cycles. The controller has three states. `ST_IDLE` waits for the first bit of a frame and latches the mode. `ST_BODY` accepts the remaining bits. `ST_FLUSH` shifts the four check bits out. The transitions are:

- `ST_IDLE` to `ST_BODY` on a first bit that is not the last bit.
- `ST_IDLE` or `ST_BODY` to `ST_FLUSH` on the last bit of an encode frame.
- `ST_IDLE` or `ST_BODY` back to `ST_IDLE` on the last bit of a check frame.
- `ST_FLUSH` to `ST_IDLE` after the fourth check bit.

Top module: `crc_serial_unit`

## Requirements
- R1: While reset is low and on the first cycle after it, `dout_valid` and `res_valid` are 0 and the remainder register is 0000.
- R2: In encode mode (`mode_sel`=0 at the first bit), each accepted message bit appears on `dout` with `dout_valid`=1 in the cycle after it is accepted, in arrival order.
- R3: After the last message bit of an encode frame, four check bits follow on `dout` on consecutive cycles, MSB first. They equal the remainder of M(x)·x^4 divided by x^4+x+1, so message 1011001 gives 1010.
- R4: During the four check-bit cycles, `din_valid`, `din`, `din_last` and `mode_sel` are ignored. The emitted bits are unchanged, and `dout_valid` is 0 in the cycle after the last check bit if no new frame has started.
- R5: In check mode (`mode_sel`=1 at the first bit), `dout_valid` stays 0. One cycle after the last codeword bit, `res_valid`=1, and `res_pass`=1 exactly when the codeword is divisible by x^4+x+1.
- R6: `res_valid` and `res_pass` hold their values until the first bit of the next frame is accepted, which clears `res_valid`, or until reset.
- R7: The mode is sampled only with the first bit of a frame. Changes of `mode_sel` later in the frame have no effect.
- R8: A frame of a single bit, marked last on its first bit, is handled correctly in both modes.
- R9: Every frame starts from a zero remainder, whatever the previous frame left behind. The register is zero whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0 = encode, 1 = check; sampled with a frame's first bit |
| din | input | 1 | Serial data bit, MSB first |
| din_valid | input | 1 | `din` carries a bit this cycle |
| din_last | input | 1 | Marks the final bit of a frame |
| dout | output | 1 | Serial output: message echo, then check bits |
| dout_valid | output | 1 | `dout` carries a bit this cycle |
| res_valid | output | 1 | Check result is available |
| res_pass | output | 1 | 1 when the checked codeword left a zero remainder |

## Verification
The bench encodes every message from 1 to 7 bits long and checks every codeword from 1 to 8 bits long. It computes the expected remainders by long division on integers, so a wrong generator tap or a wrong shift direction corrupts some check bits or pass flags. During every flush it drives garbage input that is marked valid and last, and toggles the mode in the middle of frames. A controller that let input through during the flush, or that re-sampled the mode, would emit wrong bits or echo bits in check mode. Frames follow each other with no gap after a failing check. The bench also covers single-bit frames, the hold and clear of the result, and a reset in the middle of a run. These catch a design that leaks remainder state between frames, loses or keeps the result at the wrong time, or mishandles a frame whose first bit is also its last.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

    localparam int unsigned   CRC_W   = 4;
    localparam logic [CRC_W:0] CRC_GEN = 5'b10011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_FLUSH
    } ctrl_state_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_DIV,
        OP_SHIFT,
        OP_CLEAR
    } rem_op_t;

endpackage

// File: rtl/crc_rem_core.sv
module crc_rem_core
    import crc_serial_pkg::*;
#(
    parameter int unsigned    W   = CRC_W,
    parameter logic [W:0]     GEN = CRC_GEN
) (
    input  logic    clk,
    input  logic    rst_n,
    input  rem_op_t op,
    input  logic    bit_in,
    output logic    rem_msb,
    output logic    rem_zero,
    output logic    div_zero
);

    localparam logic [W-1:0] TAPS = GEN[W-1:0];

    logic [W-1:0] rem;
    logic [W-1:0] div_next;
    logic         feedback;

    // Direct-form division step: the incoming bit joins the feedback term.
    always_comb begin
        feedback = rem[W-1] ^ bit_in;
        div_next = {rem[W-2:0], 1'b0} ^ ({W{feedback}} & TAPS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else begin
            unique case (op)
                OP_HOLD:  rem <= rem;
                OP_DIV:   rem <= div_next;
                OP_SHIFT: rem <= {rem[W-2:0], 1'b0};
                OP_CLEAR: rem <= '0;
            endcase
        end
    end

    assign rem_msb  = rem[W-1];
    assign rem_zero = (rem == '0);
    assign div_zero = (div_next == '0);

    // Shifting the check bits out brings zeros in behind them.
    assert_shift_fills_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (rem[0] == 1'b0));

    // Frame end clears the register for the next frame.
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> rem_zero);

endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
    import crc_serial_pkg::*;
#(
    parameter int unsigned W = CRC_W
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mode_sel,
    input  logic    din,
    input  logic    din_valid,
    input  logic    din_last,
    input  logic    rem_msb,
    input  logic    rem_zero,
    input  logic    div_zero,
    output rem_op_t op,
    output logic    dout,
    output logic    dout_valid,
    output logic    res_valid,
    output logic    res_pass
);

    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

    ctrl_state_t   state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          frame_chk, frame_chk_nxt;
    logic          cur_chk;
    logic          dout_nxt, dout_valid_nxt, res_valid_nxt, res_pass_nxt;

    assign cur_chk = (state == ST_IDLE) ? mode_sel : frame_chk;

    // State register and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            frame_chk  <= 1'b0;
            dout       <= 1'b0;
            dout_valid <= 1'b0;
            res_valid  <= 1'b0;
            res_pass   <= 1'b0;
        end else begin
            state      <= state_nxt;
            cnt        <= cnt_nxt;
            frame_chk  <= frame_chk_nxt;
            dout       <= dout_nxt;
            dout_valid <= dout_valid_nxt;
            res_valid  <= res_valid_nxt;
            res_pass   <= res_pass_nxt;
        end
    end

    // Next state, datapath command and next outputs.
    always_comb begin
        state_nxt      = state;
        cnt_nxt        = cnt;
        frame_chk_nxt  = frame_chk;
        op             = OP_HOLD;
        dout_nxt       = 1'b0;
        dout_valid_nxt = 1'b0;
        res_valid_nxt  = res_valid;
        res_pass_nxt   = res_pass;
        unique case (state)
            ST_IDLE, ST_BODY: begin
                if (din_valid) begin
                    op = OP_DIV;
                    if (state == ST_IDLE) begin
                        frame_chk_nxt = mode_sel;
                        res_valid_nxt = 1'b0;
                        res_pass_nxt  = 1'b0;
                    end
                    if (!cur_chk) begin
                        dout_nxt       = din;
                        dout_valid_nxt = 1'b1;
                    end
                    if (din_last) begin
                        if (cur_chk) begin
                            op            = OP_CLEAR;
                            res_valid_nxt = 1'b1;
                            res_pass_nxt  = div_zero;
                            state_nxt     = ST_IDLE;
                        end else begin
                            cnt_nxt   = '0;
                            state_nxt = ST_FLUSH;
                        end
                    end else begin
                        state_nxt = ST_BODY;
                    end
                end
            end
            ST_FLUSH: begin
                op             = OP_SHIFT;
                dout_nxt       = rem_msb;
                dout_valid_nxt = 1'b1;
                cnt_nxt        = cnt + 1'b1;
                if (cnt == CNT_LAST) begin
                    state_nxt = ST_IDLE;
                end
            end
        endcase
    end

    assert_idle_rem_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> rem_zero);

    assert_flush_emits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH) |=> dout_valid);

    assert_flush_ignores_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && din_valid) |=> (!res_valid && dout_valid));

    assert_check_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BODY && frame_chk) |=> !dout_valid);

    assert_result_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (state == ST_IDLE));

    assert_result_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !(din_valid && state == ST_IDLE)) |=> (res_valid && $stable(res_pass)));

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
    import crc_serial_pkg::*;
#(
    parameter int unsigned W   = CRC_W,
    parameter logic [W:0]  GEN = CRC_GEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic din,
    input  logic din_valid,
    input  logic din_last,
    output logic dout,
    output logic dout_valid,
    output logic res_valid,
    output logic res_pass
);

    rem_op_t op;
    logic    rem_msb;
    logic    rem_zero;
    logic    div_zero;

    crc_rem_core #(.W(W), .GEN(GEN)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .bit_in   (din),
        .rem_msb  (rem_msb),
        .rem_zero (rem_zero),
        .div_zero (div_zero)
    );

    crc_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .din        (din),
        .din_valid  (din_valid),
        .din_last   (din_last),
        .rem_msb    (rem_msb),
        .rem_zero   (rem_zero),
        .div_zero   (div_zero),
        .op         (op),
        .dout       (dout),
        .dout_valid (dout_valid),
        .res_valid  (res_valid),
        .res_pass   (res_pass)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!dout_valid && !res_valid && rem_zero));

endmodule

// File: tb/crc_serial_unit_bench.sv
module crc_serial_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n, mode_sel, din, din_valid, din_last;
    logic dout, dout_valid, res_valid, res_pass;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_serial_unit u_crc_serial_unit (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .din(din),
        .din_valid(din_valid), .din_last(din_last), .dout(dout),
        .dout_valid(dout_valid), .res_valid(res_valid), .res_pass(res_pass)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Remainder of msg * x^4 divided by x^4+x+1.
    function automatic logic [3:0] crc_of(input logic [7:0] msg, input int len);
        logic [15:0] v;
        v = 16'(msg) << 4;
        for (int b = len + 3; b >= 4; b--)
            if (v[b]) v = v ^ (16'b10011 << (b - 4));
        return v[3:0];
    endfunction

    function automatic bit divisible(input logic [7:0] cw, input int len);
        logic [15:0] v;
        v = 16'(cw);
        for (int b = len - 1; b >= 4; b--)
            if (v[b]) v = v ^ (16'b10011 << (b - 4));
        return (v[3:0] == 4'b0000);
    endfunction

    task automatic run_enc(input logic [7:0] msg, input int len, input string tag,
                           output logic [3:0] got);
        logic [3:0] exp;
        exp = crc_of(msg, len);
        got = '0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk(dout_valid && dout == msg[len-i], {tag, " R2 echo"},
                    {dout_valid, dout}, {1'b1, msg[len-i]});
                if (i == 1) chk(!res_valid, {tag, " R6 result cleared"}, res_valid, 0);
            end
            din_valid = 1'b1;
            din       = msg[len-1-i];
            din_last  = (i == len - 1);
            mode_sel  = (i == 0) ? 1'b0 : i[0]; // R7: later toggles ignored
        end
        for (int k = 0; k <= 4; k++) begin
            @(negedge clk);
            if (k == 0) begin
                chk(dout_valid && dout == msg[0], {tag, " R2 echo last"},
                    {dout_valid, dout}, {1'b1, msg[0]});
                if (len == 1) chk(!res_valid, {tag, " R6 R8 result cleared"}, res_valid, 0);
            end else begin
                got[4-k] = dout;
                chk(dout_valid && dout == exp[4-k], {tag, " R3 check bit"},
                    {dout_valid, dout}, {1'b1, exp[4-k]});
            end
            if (k < 4) begin   // R4: garbage during flush
                din_valid = 1'b1; din = k[0]; din_last = 1'b1; mode_sel = ~k[0];
            end else begin
                din_valid = 1'b0; din_last = 1'b0; mode_sel = 1'b0;
            end
        end
        @(negedge clk);
        chk(!dout_valid, {tag, " R4 flush input ignored"}, dout_valid, 0);
    endtask

    task automatic run_chk(input logic [7:0] cw, input int len, input string tag);
        bit exp;
        exp = divisible(cw, len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0) chk(!dout_valid, {tag, " R5 no echo"}, dout_valid, 0);
            din_valid = 1'b1;
            din       = cw[len-1-i];
            din_last  = (i == len - 1);
            mode_sel  = (i == 0) ? 1'b1 : i[0]; // R7
        end
        @(negedge clk);
        din_valid = 1'b0; din_last = 1'b0;
        chk(res_valid && res_pass == exp, {tag, " R5 result"},
            {res_valid, res_pass}, {1'b1, exp});
        chk(!dout_valid, {tag, " R5 no echo"}, dout_valid, 0);
        for (int h = 0; h < 2; h++) begin
            @(negedge clk);
            din = h[0]; mode_sel = ~h[0];
            chk(res_valid && res_pass == exp, {tag, " R6 result held"},
                {res_valid, res_pass}, {1'b1, exp});
        end
    endtask

    initial begin
        logic [3:0] got;
        rst_n = 1'b0; mode_sel = 1'b0; din = 1'b0; din_valid = 1'b0; din_last = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dout_valid && !res_valid, "R1 reset outputs", {dout_valid, res_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dout_valid && !res_valid, "R1 after reset", {dout_valid, res_valid}, 0);

        // Directed worked example.
        run_enc(8'b1011001, 7, "R3 example", got);
        chk(got == 4'b1010, "R3 1011001 gives 1010", got, 4'b1010);

        // Single-bit frames.
        run_enc(8'b1, 1, "R8", got);
        chk(got == 4'b0011, "R8 one-bit encode", got, 4'b0011);
        run_chk(8'b0, 1, "R8");
        run_chk(8'b1, 1, "R8");

        // Exhaustive encode, each followed by a check of the produced codeword.
        for (int len = 1; len <= 7; len++) begin
            for (int m = 0; m < (1 << len); m++) begin
                run_enc(8'(m), len, "R3 sweep", got);
                if (len <= 4)
                    run_chk(8'((m << 4) | got), len + 4, "R5 R9 codeword");
            end
        end

        // Exhaustive check of every codeword up to 8 bits, back to back.
        for (int len = 1; len <= 8; len++)
            for (int c = 0; c < (1 << len); c++)
                run_chk(8'(c), len, "R5 R9 sweep");

        // Reset in the middle of a run clears the held result.
        run_chk(8'b00010011, 8, "R5 pre-reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!res_valid && !dout_valid, "R1 mid-run reset", {res_valid, dout_valid}, 0);
        rst_n = 1'b1;
        run_enc(8'b1011001, 7, "R1 R9 after reset", got);
        chk(got == 4'b1010, "R9 after reset", got, 4'b1010);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule